// File: doc/BRIEF.md
# Interrupt Controller Global Timer Channel

This block is a single down-counting timer channel for a multiprocessor interrupt controller. Software programs a base count and a frequency word over a simple 32-bit register bus. The channel then counts down once for each cycle on which an external tick enable is high. When the count runs out it reloads from the base count, flips a toggle flag and sends a one-cycle event to the interrupt source slot that serves this timer. The prescaler that produces the tick, and the routing of the resulting interrupt, both sit outside the block.

Two register bits carry control. The top bit of the base count stops counting while it is set. The top bit of the current count is a status flag that flips at every terminal count. The toggle flag is cleared when software releases the stop bit, which gives software a known starting phase.

Top module: `gtimer_channel`

## Requirements
- R1: After reset: the current count reads 0x0000_0000, the base count reads 0x8000_0000, the frequency word reads the FREQ_RESET parameter, and `tmr_event` is low.
- R2: While bit 31 of the base count (inhibit) is 1, ticks do not change the current count.
- R3: When inhibit is 0 and the count field (current count bits 30:0) is greater than 1, each tick lowers the count field by one. Cycles without a tick leave it unchanged.
- R4: A tick that arrives with the count field at 0 loads the field from base-count bits 30:0. It does not flip the toggle and does not raise an event.
- R5: A tick that arrives with the count field at 1 is a terminal count. It reloads the field from base-count bits 30:0 and flips current-count bit 31 (the toggle). `tmr_event` is high for the one cycle after that clock edge, so back-to-back terminal counts give back-to-back event cycles.
- R6: A base-count write clears the toggle only when three things are true at the same time: the toggle is 1, the stored inhibit is 1, and the written bit 31 is 0. Any other base-count write leaves the toggle unchanged.
- R7: Bus writes to the current-count address have no effect.
- R8: The frequency word is a 32-bit read/write register.
- R9: The address map is: current count 0x00, base count 0x10, frequency word 0x40. Offsets 0x20 and 0x30 belong to the interrupt source slot. Here they read as 0, and writes to them are ignored. Read data appears on `bus_rdata` in the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-enable strobe from the prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 7 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tmr_event | output | 1 | One-cycle terminal-count event to the source slot |

## Verification
The hardest state to reach is the toggle-clear condition, because it needs the toggle set, inhibit set and a write with inhibit clear, all at the same moment. The stimulus gets there in steps. It runs the counter through an odd number of terminal counts so the toggle stays at 1. It then writes base values in turn: with inhibit already clear, with inhibit being set, and finally with inhibit being released. Only the last write may clear the flag. Back-to-back terminal counts with a base count of 1 and a continuous tick show that event pulses are not merged. A base count of 0 shows that the counter stays at zero without producing events.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;
  localparam int DW   = 32;
  localparam int CW   = DW - 1;
  localparam int AW   = 7;

  localparam logic [AW-1:0] OFS_CUR  = 7'h00;
  localparam logic [AW-1:0] OFS_BASE = 7'h10;
  localparam logic [AW-1:0] OFS_FREQ = 7'h40;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CUR  = 2'd1,
    SEL_BASE = 2'd2,
    SEL_FREQ = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gtimer_regs.sv
module gtimer_regs
  import gtimer_pkg::*;
#(
  parameter logic [DW-1:0] FREQ_RESET = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] cur_val,
  output logic [DW-1:0] base_q,
  output logic          toggle_clr
);
  reg_sel_e      sel;
  logic [DW-1:0] freq_q;
  logic [DW-1:0] rd_mux;

  always_comb begin
    unique case (bus_addr)
      OFS_CUR:  sel = SEL_CUR;
      OFS_BASE: sel = SEL_BASE;
      OFS_FREQ: sel = SEL_FREQ;
      default:  sel = SEL_NONE;
    endcase
  end

  assign toggle_clr = bus_wr && (sel == SEL_BASE) && base_q[DW-1]
                      && !bus_wdata[DW-1] && cur_val[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= {1'b1, {CW{1'b0}}};
      freq_q <= FREQ_RESET;
    end else if (bus_wr) begin
      if (sel == SEL_BASE) base_q <= bus_wdata;
      if (sel == SEL_FREQ) freq_q <= bus_wdata;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CUR:  rd_mux = cur_val;
      SEL_BASE: rd_mux = base_q;
      SEL_FREQ: rd_mux = freq_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == 7'h20 || bus_addr == 7'h30)) |=> (bus_rdata == '0));

  p_freq_rw_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_FREQ && !$past(bus_wr)) |=> (bus_rdata == $past(freq_q)));
endmodule

// File: rtl/gtimer_counter.sv
module gtimer_counter
  import gtimer_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          inhibit,
  input  logic [CW-1:0] reload,
  input  logic          toggle_clr,
  output logic [DW-1:0] cur_val,
  output logic          evt_q
);
  logic [CW-1:0] cnt_q;
  logic          tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (toggle_clr) tog_q <= 1'b0;
      if (tick_en && !inhibit) begin
        if (cnt_q == '0) begin
          cnt_q <= reload;
        end else if (cnt_q == CW'(1)) begin
          cnt_q <= reload;
          tog_q <= ~tog_q;
          evt_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end

  assign cur_val = {tog_q, cnt_q};

  p_hold_inhibit_r2: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> $stable(cnt_q));

  p_decrement_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !inhibit && cnt_q > CW'(1)) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  p_event_flips_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_q) |-> (tog_q != $past(tog_q)));
endmodule

// File: rtl/gtimer_channel.sv
module gtimer_channel
  import gtimer_pkg::*;
#(
  parameter logic [31:0] FREQ_RESET = 32'd0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_en,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [6:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tmr_event
);
  logic [DW-1:0] base_q;
  logic [DW-1:0] cur_val;
  logic          toggle_clr;

  gtimer_regs #(.FREQ_RESET(FREQ_RESET)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cur_val(cur_val), .base_q(base_q), .toggle_clr(toggle_clr)
  );

  gtimer_counter u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .inhibit(base_q[DW-1]), .reload(base_q[CW-1:0]),
    .toggle_clr(toggle_clr), .cur_val(cur_val), .evt_q(tmr_event)
  );

  p_toggle_cleared_r6: assert property (@(posedge clk) disable iff (rst)
    toggle_clr |=> !cur_val[DW-1]);

  p_cur_readonly_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_CUR && base_q[DW-1] && !toggle_clr) |=> $stable(cur_val));
endmodule

// File: tb/tb_gtimer_channel.sv
`timescale 1ns/1ps
module tb_gtimer_channel;
  localparam logic [31:0] FREQ_RST = 32'd4160000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tmr_event;

  int n_checks = 0;
  int n_fail   = 0;
  int evt_total = 0;
  bit done = 1'b0;
  logic rd_d = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  gtimer_channel #(.FREQ_RESET(FREQ_RST)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_event(tmr_event)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_d <= bus_rd;

  // Monitor: pops the scoreboard when read data is due
  always @(negedge clk) begin
    if (tmr_event) evt_total++;
    if (rd_d && !rst) begin
      if (exp_q.size() == 0) check(bus_rdata, 32'hx, "scoreboard empty");
      else check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic do_read(input logic [6:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #500000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check({31'd0, tmr_event}, 32'd0, "R1 event low");
    do_read(7'h00, 32'h0000_0000, "R1 current count");
    do_read(7'h10, 32'h8000_0000, "R1 base count");
    do_read(7'h40, FREQ_RST,      "R1 frequency");
    // R2 inhibited
    ticks(5);
    do_read(7'h00, 32'h0000_0000, "R2 no count while inhibited");
    check(evt_total, 0, "R2 no events while inhibited");
    // R7 write to current count ignored
    do_write(7'h00, 32'h0000_1234);
    do_read(7'h00, 32'h0000_0000, "R7 current count read-only");
    // R4 load from zero
    do_write(7'h10, 32'h0000_0003);
    ticks(1);
    do_read(7'h00, 32'h0000_0003, "R4 load from zero");
    check(evt_total, 0, "R4 no event on load");
    // R3 decrement and idle hold
    ticks(1);
    do_read(7'h00, 32'h0000_0002, "R3 decrement");
    repeat (5) @(negedge clk);
    do_read(7'h00, 32'h0000_0002, "R3 hold without tick");
    ticks(1);
    do_read(7'h00, 32'h0000_0001, "R3 decrement to one");
    // R5 terminal count
    ticks(1);
    do_read(7'h00, 32'h8000_0003, "R5 reload and toggle");
    check(evt_total, 1, "R5 one event");
    ticks(3);
    do_read(7'h00, 32'h0000_0003, "R5 toggle back");
    ticks(3);
    do_read(7'h00, 32'h8000_0003, "R5 toggle set again");
    check(evt_total, 3, "R5 event count");
    // R6 toggle clear conditions
    do_write(7'h10, 32'h0000_0005);
    do_read(7'h00, 32'h8000_0003, "R6 kept: inhibit not set");
    do_write(7'h10, 32'h8000_0005);
    do_read(7'h00, 32'h8000_0003, "R6 kept: written inhibit set");
    ticks(4);
    do_read(7'h00, 32'h8000_0003, "R2 hold after re-inhibit");
    do_write(7'h10, 32'h0000_0005);
    do_read(7'h00, 32'h0000_0003, "R6 cleared on release");
    ticks(3);
    do_read(7'h00, 32'h8000_0005, "R5 reload from new base");
    check(evt_total, 4, "R5 event after new base");
    // R5 base of one: event every tick, including back-to-back
    do_write(7'h10, 32'h0000_0001);
    ticks(4);
    ticks(2);
    do_read(7'h00, 32'h8000_0001, "R5 base one toggles");
    check(evt_total, 6, "R5 base one events");
    @(negedge clk); tick_en = 1'b1;
    repeat (3) @(negedge clk);
    tick_en = 1'b0;
    @(negedge clk);
    check(evt_total, 9, "R5 back-to-back events");
    do_read(7'h00, 32'h0000_0001, "R5 three flips");
    // R8 frequency word
    do_write(7'h40, 32'hDEAD_BEEF);
    do_read(7'h40, 32'hDEAD_BEEF, "R8 frequency read/write");
    // R9 reserved offsets
    do_write(7'h20, 32'hFFFF_FFFF);
    do_read(7'h20, 32'h0000_0000, "R9 offset 0x20 reads zero");
    do_write(7'h30, 32'hFFFF_FFFF);
    do_read(7'h30, 32'h0000_0000, "R9 offset 0x30 reads zero");
    do_read(7'h10, 32'h0000_0001, "R9 base untouched");
    // R4 base zero: final terminal then parked at zero
    do_write(7'h10, 32'h0000_0000);
    ticks(1);
    ticks(3);
    do_read(7'h00, 32'h8000_0000, "R4 parked at zero");
    check(evt_total, 10, "R4 no events while parked");
    repeat (3) @(negedge clk);
    check(exp_q.size(), 0, "scoreboard drained");
    summary();
  end
endmodule